// File: doc/BRIEF.md
# Sleep and Wakeup Power Controller

This block holds the power mode of a bus slave. The mode is one of boot, normal, sleep, standby (a locally started wakeup that is being broadcast) and resume (a wakeup heard on the bus). It decides when the device sleeps, which comes from a falling local sleep pin, a decoded sleep command, or a period with no bus reception while auto-sleep is enabled. It also decides when the device wakes, which comes from either edge on a local wake pin or a wakeup message heard during a listen window.

It drives the host inhibit line, the host data line that is held low around a wakeup, a request to clear the slave's output pins, a request to the transmitter to send the wakeup broadcast, and the receiver enable. While the device sleeps, the receiver enable opens only for a short window in each listen period. All timing runs from microsecond and millisecond ticks derived from the system clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Once reset is released, `inh_o` is 0, `hdo_o` is 1, and `rx_en_o`, `wake_tx_o` and `clr_out_o` are 0. After BOOT_MS millisecond ticks the mode becomes normal, and in normal mode `rx_en_o` is 1.
- R2: The inhibit target is 0 in sleep and 1 in every other mode. `inh_o` takes the new target on the INH_DLY_US-th microsecond tick after the target changes, and only on a microsecond tick.
- R3: A falling edge on `sleep_n_i` seen in normal mode enters sleep on the next clock. `rx_en_o` then drops and `clr_out_o` stays 0, so the slave outputs are kept.
- R4: A `sleep_cmd_i` strobe in normal mode enters sleep on the next clock, with `clr_out_o` staying 0.
- R5: With `auto_sleep_en_i` high in normal mode, AUTO_SLEEP_MS millisecond ticks without a `bus_act_i` strobe enter sleep. Each `bus_act_i` strobe restarts the count. While a sleep entered this way lasts, `clr_out_o` is 1. With the enable low, no timeout occurs.
- R6: In sleep, the listen phase counts millisecond ticks from sleep entry, modulo LISTEN_PERIOD_MS. `rx_en_o` is 1 while the phase is at least LISTEN_PERIOD_MS-LISTEN_MS, so each window is exactly LISTEN_MS milliseconds long.
- R7: A `wake_msg_i` strobe while `rx_en_o` is 1 in sleep moves to resume. In resume `hdo_o` is 0, and the mode returns to normal on the clock after `inh_o` reads 1. A `wake_msg_i` strobe outside the window has no effect.
- R8: Either edge of `wake_pin_i` in sleep moves to standby. In standby `wake_tx_o` is 1 and `rx_en_o` is 0, and `hdo_o` goes to 0 after HDO_DLY_US microsecond ticks. After WAKE_MSG_MS millisecond ticks the mode becomes normal, with `hdo_o` 1.
- R9: A low `sleep_n_i` that persists after a wakeup does not put the device back to sleep. Only a new falling edge seen in normal mode does.
- R10: A `wake_pin_i` edge outside sleep and a `sleep_cmd_i` strobe outside normal mode are ignored.
- R11: When a wake pin edge and an in-window wakeup message arrive in the same cycle, the pin wins and the mode becomes standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n_i | input | 1 | Local sleep request pin, active low, synchronous |
| sleep_cmd_i | input | 1 | One-cycle strobe: sleep command decoded |
| bus_act_i | input | 1 | One-cycle strobe: valid reception on the bus |
| wake_msg_i | input | 1 | One-cycle strobe: wakeup message detected |
| wake_pin_i | input | 1 | Local wake pin, either edge active, synchronous |
| auto_sleep_en_i | input | 1 | Enables the inactivity sleep timeout |
| inh_o | output | 1 | Host inhibit line, high while awake |
| hdo_o | output | 1 | Host data line, low around a wakeup |
| clr_out_o | output | 1 | Request to hold slave outputs at zero |
| wake_tx_o | output | 1 | Request to transmit the wakeup broadcast |
| rx_en_o | output | 1 | Receiver enable |

## Verification
The block is driven through every way into sleep (pin edge, command and inactivity timeout) and every way out (rising pin edge, falling pin edge and in-window bus message). This separates the paths that keep the outputs from the path that clears them, and the broadcast wakeup from the silent resume. Wakeup messages are placed both inside and outside a listen window, and also in the same cycle as a pin edge, to show that the window gates reception and that the pin has priority. A low sleep pin held across a wakeup, with commands and pin edges sent in the wrong mode, shows that only fresh events in the right mode change the mode. A reference model steps the same tick arithmetic on every clock, so any shift in INH delay, HDO delay, window position or timeout length shows up as a mismatch.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    PM_BOOT    = 3'd0,
    PM_NORMAL  = 3'd1,
    PM_SLEEP   = 3'd2,
    PM_STANDBY = 3'd3,
    PM_RESUME  = 3'd4
  } pm_state_t;

  typedef enum logic {
    CAUSE_KEEP = 1'b0,
    CAUSE_AUTO = 1'b1
  } sleep_cause_t;

endpackage

// File: rtl/pwr_tick_timer.sv
// Wrapping tick counter: done_o pulses on the LIMIT-th tick after a clear.
module pwr_tick_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = !clr_i && tick_i && (cnt_q == LAST);

endmodule

// File: rtl/pwr_tick_gen.sv
// Microsecond and millisecond strobes from the system clock.
module pwr_tick_gen #(
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic us_tick_o,
  output logic ms_tick_o
);
  pwr_tick_timer #(.LIMIT(CLK_PER_US)) u_us (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(1'b1), .done_o(us_tick_o)
  );

  pwr_tick_timer #(.LIMIT(US_PER_MS)) u_ms (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .tick_i(us_tick_o), .done_o(ms_tick_o)
  );

  p_ms_inside_us_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick_o |-> us_tick_o)
    else $error("ms tick outside a us tick");

endmodule

// File: rtl/pwr_listen_sched.sv
// Receiver duty cycle while asleep: phase counts ms from sleep entry.
module pwr_listen_sched #(
  parameter int PERIOD = 32,
  parameter int LISTEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  output logic win_o
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);
  localparam logic [W-1:0] OPEN = W'(PERIOD - LISTEN);

  logic [W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!run_i) begin
      phase_d = '0;
    end else if (tick_i) begin
      phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign win_o = (phase_q >= OPEN);

  p_window_opens_on_tick_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) |-> $past(tick_i) && $past(run_i))
    else $error("listen window opened without a ms tick");

  p_window_shut_at_entry_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    ((OPEN != '0) && $rose(run_i)) |-> !win_o)
    else $error("listen window open on sleep entry");

endmodule

// File: rtl/pwr_inh_follow.sv
// INH follows its target after DLY microsecond ticks of disagreement.
module pwr_inh_follow #(
  parameter int DLY = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic target_i,
  input  logic tick_i,
  output logic inh_o
);
  localparam int W = $clog2(DLY + 1);
  localparam logic [W-1:0] LAST = W'(DLY - 1);

  logic         inh_q, inh_d;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    inh_d = inh_q;
    cnt_d = cnt_q;
    if (inh_q == target_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        inh_d = target_i;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inh_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      inh_q <= inh_d;
      cnt_q <= cnt_d;
    end
  end

  assign inh_o = inh_q;

  p_inh_moves_on_tick_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q != $past(inh_q)) |-> ($past(tick_i) && ($past(target_i) == inh_q)))
    else $error("INH changed off a tick or away from its target");

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CLK_PER_US       = 125,
  parameter int US_PER_MS        = 1000,
  parameter int INH_DLY_US       = 40,
  parameter int HDO_DLY_US       = 100,
  parameter int BOOT_MS          = 3,
  parameter int AUTO_SLEEP_MS    = 8000,
  parameter int LISTEN_PERIOD_MS = 32,
  parameter int LISTEN_MS        = 6,
  parameter int WAKE_MSG_MS      = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n_i,
  input  logic sleep_cmd_i,
  input  logic bus_act_i,
  input  logic wake_msg_i,
  input  logic wake_pin_i,
  input  logic auto_sleep_en_i,
  output logic inh_o,
  output logic hdo_o,
  output logic clr_out_o,
  output logic wake_tx_o,
  output logic rx_en_o
);
  localparam int HW = $clog2(HDO_DLY_US + 1);
  localparam logic [HW-1:0] HDO_LAST = HW'(HDO_DLY_US);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // ticks and timers
  logic us_tick, ms_tick;
  logic boot_done, idle_done, tx_done, listen_win;
  logic idle_clr;

  pm_state_t    state_q, state_d;
  sleep_cause_t cause_q, cause_d;

  pwr_tick_gen #(.CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)) u_ticks (
    .clk(clk), .rst_n(rst_int_n), .us_tick_o(us_tick), .ms_tick_o(ms_tick)
  );

  pwr_tick_timer #(.LIMIT(BOOT_MS)) u_boot (
    .clk(clk), .rst_n(rst_int_n), .clr_i(state_q != PM_BOOT),
    .tick_i(ms_tick), .done_o(boot_done)
  );

  assign idle_clr = !(state_q == PM_NORMAL && auto_sleep_en_i) || bus_act_i;

  pwr_tick_timer #(.LIMIT(AUTO_SLEEP_MS)) u_idle (
    .clk(clk), .rst_n(rst_int_n), .clr_i(idle_clr),
    .tick_i(ms_tick), .done_o(idle_done)
  );

  pwr_tick_timer #(.LIMIT(WAKE_MSG_MS)) u_txlen (
    .clk(clk), .rst_n(rst_int_n), .clr_i(state_q != PM_STANDBY),
    .tick_i(ms_tick), .done_o(tx_done)
  );

  pwr_listen_sched #(.PERIOD(LISTEN_PERIOD_MS), .LISTEN(LISTEN_MS)) u_listen (
    .clk(clk), .rst_n(rst_int_n), .run_i(state_q == PM_SLEEP),
    .tick_i(ms_tick), .win_o(listen_win)
  );

  pwr_inh_follow #(.DLY(INH_DLY_US)) u_inh (
    .clk(clk), .rst_n(rst_int_n), .target_i(state_q != PM_SLEEP),
    .tick_i(us_tick), .inh_o(inh_o)
  );

  // pin edge detection
  logic sleep_n_q, wake_q;
  logic sleep_fall, wake_edge;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sleep_n_q <= 1'b1;
      wake_q    <= 1'b0;
    end else begin
      sleep_n_q <= sleep_n_i;
      wake_q    <= wake_pin_i;
    end
  end

  assign sleep_fall = sleep_n_q && !sleep_n_i;
  assign wake_edge  = wake_q ^ wake_pin_i;

  // mode state machine
  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      PM_BOOT: begin
        if (boot_done) state_d = PM_NORMAL;
      end
      PM_NORMAL: begin
        if (sleep_fall || sleep_cmd_i) begin
          state_d = PM_SLEEP;
          cause_d = CAUSE_KEEP;
        end else if (idle_done) begin
          state_d = PM_SLEEP;
          cause_d = CAUSE_AUTO;
        end
      end
      PM_SLEEP: begin
        if (wake_edge)                     state_d = PM_STANDBY;
        else if (wake_msg_i && listen_win) state_d = PM_RESUME;
      end
      PM_STANDBY: begin
        if (tx_done) state_d = PM_NORMAL;
      end
      PM_RESUME: begin
        if (inh_o) state_d = PM_NORMAL;
      end
      default: state_d = PM_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= PM_BOOT;
      cause_q <= CAUSE_KEEP;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  // HDO delay in standby (saturating us count)
  logic [HW-1:0] hdo_cnt_q, hdo_cnt_d;

  always_comb begin
    hdo_cnt_d = hdo_cnt_q;
    if (state_q != PM_STANDBY) begin
      hdo_cnt_d = '0;
    end else if (us_tick && (hdo_cnt_q != HDO_LAST)) begin
      hdo_cnt_d = hdo_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) hdo_cnt_q <= '0;
    else            hdo_cnt_q <= hdo_cnt_d;
  end

  // outputs
  assign hdo_o     = !(((state_q == PM_STANDBY) && (hdo_cnt_q == HDO_LAST)) ||
                       (state_q == PM_RESUME));
  assign wake_tx_o = (state_q == PM_STANDBY);
  assign clr_out_o = (state_q == PM_SLEEP) && (cause_q == CAUSE_AUTO);
  assign rx_en_o   = (state_q == PM_NORMAL) || ((state_q == PM_SLEEP) && listen_win);

  // checks
  p_clear_needs_auto_r5 : assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(clr_out_o) |-> $past(auto_sleep_en_i) && !$past(bus_act_i))
    else $error("output clear without auto-sleep timeout");

  p_resume_needs_window_r7 : assert property (@(posedge clk) disable iff (!rst_int_n)
    ($fell(hdo_o) && !wake_tx_o) |-> ($past(rx_en_o) && $past(wake_msg_i)))
    else $error("resume without in-window wakeup message");

  p_broadcast_needs_edge_r8 : assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wake_tx_o) |-> ($past(wake_pin_i) != $past(wake_pin_i, 2)))
    else $error("wakeup broadcast without a wake pin edge");

  p_inh_before_hdo_r8 : assert property (@(posedge clk) disable iff (!rst_int_n)
    (wake_tx_o && !hdo_o) |-> inh_o)
    else $error("HDO low before INH raised during broadcast");

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int CPU = 4;
  localparam int UPM = 8;
  localparam int IDLY = 3;
  localparam int HDLY = 6;
  localparam int BOOT = 2;
  localparam int AUTO = 5;
  localparam int PER = 8;
  localparam int LIS = 2;
  localparam int WMS = 3;
  localparam int MSC = CPU * UPM;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic sleep_n = 1'b1, sleep_cmd = 1'b0, bus_act = 1'b0;
  logic wake_msg = 1'b0, wake_pin = 1'b0, auto_en = 1'b0;
  logic inh, hdo, clr_out, wake_tx, rx_en;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(
    .CLK_PER_US(CPU), .US_PER_MS(UPM), .INH_DLY_US(IDLY), .HDO_DLY_US(HDLY),
    .BOOT_MS(BOOT), .AUTO_SLEEP_MS(AUTO), .LISTEN_PERIOD_MS(PER),
    .LISTEN_MS(LIS), .WAKE_MSG_MS(WMS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n), .sleep_cmd_i(sleep_cmd),
    .bus_act_i(bus_act), .wake_msg_i(wake_msg), .wake_pin_i(wake_pin),
    .auto_sleep_en_i(auto_en), .inh_o(inh), .hdo_o(hdo), .clr_out_o(clr_out),
    .wake_tx_o(wake_tx), .rx_en_o(rx_en)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // modes: 0 boot, 1 normal, 2 sleep, 3 standby, 4 resume
  int m_rs1 = 0, m_rs2 = 0;
  int st = 0, cause_auto = 0, us_c = 0, ms_c = 0, boot_c = 0, idle_c = 0;
  int tx_c = 0, std_c = 0, ph = 0, m_inh = 0, inh_c = 0, sn_q = 1, wk_q = 0;

  task automatic m_reset();
    st = 0; cause_auto = 0; us_c = 0; ms_c = 0; boot_c = 0; idle_c = 0;
    tx_c = 0; std_c = 0; ph = 0; m_inh = 0; inh_c = 0; sn_q = 1; wk_q = 0;
  endtask

  task automatic m_step();
    bit ut, mt, sfall, wedge, win, iclr, idone, tgt;
    int nst, ncause;
    ut = (us_c == CPU - 1);
    mt = ut && (ms_c == UPM - 1);
    sfall = (sn_q == 1) && !sleep_n;
    wedge = (wk_q != int'(wake_pin));
    win = (ph >= PER - LIS);
    iclr = !(st == 1 && auto_en) || bus_act;
    idone = !iclr && mt && (idle_c == AUTO - 1);
    nst = st; ncause = cause_auto;
    case (st)
      0: if (mt && boot_c == BOOT - 1) nst = 1;
      1: if (sfall || sleep_cmd) begin nst = 2; ncause = 0; end
         else if (idone) begin nst = 2; ncause = 1; end
      2: if (wedge) nst = 3; else if (wake_msg && win) nst = 4;
      3: if (mt && tx_c == WMS - 1) nst = 1;
      4: if (m_inh == 1) nst = 1;
      default: nst = 0;
    endcase
    if (ut) ms_c = (ms_c == UPM - 1) ? 0 : ms_c + 1;
    us_c = ut ? 0 : us_c + 1;
    if (st != 0) boot_c = 0; else if (mt) boot_c = (boot_c == BOOT - 1) ? 0 : boot_c + 1;
    if (iclr) idle_c = 0; else if (mt) idle_c = (idle_c == AUTO - 1) ? 0 : idle_c + 1;
    if (st != 3) tx_c = 0; else if (mt) tx_c = (tx_c == WMS - 1) ? 0 : tx_c + 1;
    if (st != 3) std_c = 0; else if (ut && std_c < HDLY) std_c = std_c + 1;
    if (st != 2) ph = 0; else if (mt) ph = (ph == PER - 1) ? 0 : ph + 1;
    tgt = (st != 2);
    if (m_inh == int'(tgt)) inh_c = 0;
    else if (ut) begin
      if (inh_c == IDLY - 1) begin m_inh = tgt; inh_c = 0; end
      else inh_c = inh_c + 1;
    end
    sn_q = sleep_n; wk_q = wake_pin;
    st = nst; cause_auto = ncause;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_reset();
    end else begin
      if (m_rs2 == 0) m_reset(); else m_step();
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check(cur_req, "model inh", inh, 1'(m_inh));
      check(cur_req, "model hdo", hdo, !((st == 3 && std_c == HDLY) || st == 4));
      check(cur_req, "model wake_tx", wake_tx, st == 3);
      check(cur_req, "model clr_out", clr_out, st == 2 && cause_auto == 1);
      check(cur_req, "model rx_en", rx_en, st == 1 || (st == 2 && ph >= PER - LIS));
    end
  end

  // ---------------- watchdog ----------------
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_rx(logic lvl, output int n);
    n = 0;
    while (rx_en !== lvl) begin @(negedge clk); n++; end
  endtask

  task automatic wait_tx_end();
    while (wake_tx !== 1'b0) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  int n, hi;

  initial begin
    #1 rst_n = 1'b0;
    cmp_on = 1'b1;
    cyc(3);
    // R1: reset state
    check("R1", "reset inh", inh, 1'b0);
    check("R1", "reset hdo", hdo, 1'b1);
    check("R1", "reset rx_en", rx_en, 1'b0);
    check("R1", "reset wake_tx", wake_tx, 1'b0);
    check("R1", "reset clr_out", clr_out, 1'b0);
    rst_n = 1'b1;
    cyc((BOOT + 1) * MSC + 4);
    check("R1", "normal after boot rx_en", rx_en, 1'b1);
    check("R2", "inh high in normal", inh, 1'b1);

    // R4: command sleep, then listen window, then bus wakeup
    cur_req = "R4";
    pulse(sleep_cmd);
    check("R4", "rx off after command", rx_en, 1'b0);
    check("R4", "outputs kept", clr_out, 1'b0);
    cyc(5 * CPU);
    check("R2", "inh low in sleep", inh, 1'b0);
    cur_req = "R6";
    wait_rx(1'b1, n);
    n = n + 5 * CPU + 1;
    check("R6", "window opens after PER-LIS ms", (n >= (PER - LIS - 1) * MSC) && (n <= (PER - LIS) * MSC + 2), 1'b1);
    hi = 0;
    while (rx_en === 1'b1) begin @(negedge clk); hi++; end
    check("R6", "window length LIS ms", hi == LIS * MSC, 1'b1);
    cur_req = "R7";
    wait_rx(1'b1, n);
    pulse(wake_msg);
    check("R7", "hdo low on bus wakeup", hdo, 1'b0);
    cyc(IDLY * CPU + 3);
    check("R7", "hdo restored", hdo, 1'b1);
    check("R7", "normal after resume", rx_en, 1'b1);
    check("R2", "inh raised after resume", inh, 1'b1);

    // R3: pin sleep, R8 rising wake edge
    cur_req = "R3";
    sleep_n = 1'b0; @(negedge clk);
    check("R3", "rx off after pin", rx_en, 1'b0);
    check("R3", "outputs kept", clr_out, 1'b0);
    cyc(MSC);
    cur_req = "R8";
    wake_pin = 1'b1; @(negedge clk);
    check("R8", "broadcast on rising edge", wake_tx, 1'b1);
    check("R8", "rx off while broadcasting", rx_en, 1'b0);
    cyc((HDLY + 1) * CPU + 1);
    check("R8", "hdo low during broadcast", hdo, 1'b0);
    check("R2", "inh high in standby", inh, 1'b1);
    wait_tx_end();
    check("R8", "hdo high after broadcast", hdo, 1'b1);
    check("R8", "normal after broadcast", rx_en, 1'b1);

    // R9: held-low sleep pin does not re-sleep
    cur_req = "R9";
    cyc(4 * MSC);
    check("R9", "stays awake with low pin", rx_en, 1'b1);
    sleep_n = 1'b1; cyc(3);
    sleep_n = 1'b0; @(negedge clk);
    check("R9", "new falling edge sleeps", rx_en, 1'b0);

    // R8 falling edge, R10 command during standby
    cur_req = "R8";
    cyc(MSC);
    wake_pin = 1'b0; @(negedge clk);
    check("R8", "broadcast on falling edge", wake_tx, 1'b1);
    cur_req = "R10";
    cyc(5);
    pulse(sleep_cmd);
    wait_tx_end();
    cyc(2 * MSC);
    check("R10", "command in standby ignored", rx_en, 1'b1);
    sleep_n = 1'b1;
    wake_pin = 1'b1; cyc(3);
    check("R10", "wake edge in normal ignored", wake_tx, 1'b0);

    // R5: auto sleep
    cur_req = "R5";
    auto_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc(3 * MSC);
      pulse(bus_act);
    end
    check("R5", "bus activity keeps awake", rx_en, 1'b1);
    wait_rx(1'b0, n);
    check("R5", "timeout near AUTO ms", (n >= (AUTO - 1) * MSC) && (n <= AUTO * MSC + 2), 1'b1);
    check("R5", "clear request on auto sleep", clr_out, 1'b1);
    auto_en = 1'b0;
    cur_req = "R7";
    pulse(wake_msg);
    check("R7", "message outside window ignored hdo", hdo, 1'b1);
    check("R7", "message outside window ignored rx", rx_en, 1'b0);
    check("R5", "clear held while asleep", clr_out, 1'b1);

    // R11: pin edge beats in-window message
    cur_req = "R11";
    wait_rx(1'b1, n);
    wake_msg = 1'b1; wake_pin = 1'b0; @(negedge clk);
    wake_msg = 1'b0;
    check("R11", "pin wins to standby", wake_tx, 1'b1);
    check("R11", "no resume hdo", hdo, 1'b1);
    check("R5", "clear dropped on wake", clr_out, 1'b0);
    wait_tx_end();

    // R5: disabled timeout
    cur_req = "R5";
    cyc((AUTO + 3) * MSC);
    check("R5", "no timeout when disabled", rx_en, 1'b1);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule